// File: doc/BRIEF.md
# Receive-channel mode control decoder

This block accepts a 4-bit mode code from a host. The host marks the code with an active-low strobe that has no relation to the system clock. The block brings the strobe into the clock domain through a two-stage synchronizer and finds its falling edge. On that edge it loads the code into a small state register.

The state drives three sets of outputs:
- a high-speed select for each receive channel;
- a one-hot test-injection select for the channels;
- a held quiescent flag, plus a one-cycle restart pulse that returns the channel service sequencer to its home priority (channel 0 first).

Each load opens a short settling window. During the window the test selects are forced low, so two channels' test paths are never enabled at the same moment while one test channel changes to another.

The interface has no data stream and no back-pressure. The strobe and code are plain control pins. The host keeps to the strobe pulse widths and the code hold time given below. The block never stalls the host.

Top module: `mode_ctl_dec`

## Requirements
- R1: While `rst_n` is low and right after it rises, `chan_fast`, `chan_test`, `quiescent`, `restart` and `settling` are all zero.
- R2: Speed codes set `chan_fast` (bit i = channel i), end test mode and clear quiescent:
  - 0000 gives 0x00
  - 0001 gives 0x01
  - 0010 gives 0x02
  - 0011 gives 0x03
  - 0100 gives 0x07
  - all channels at or above NFAST (default 3) are always low speed.
- R3: Codes 0101 and 0110 end test mode. They leave `chan_fast` and `quiescent` unchanged.
- R4: Code 0111 clears `chan_fast`, ends test mode and sets `quiescent`. It also raises `restart` for exactly one cycle, in the same cycle that the new state appears.
- R5: `quiescent` stays set through unused codes and test codes. Only a speed code clears it.
- R6: Code 1ccc sets bit ccc of `chan_test` and no other bit. `chan_fast` is unchanged, including when one test channel changes to another.
- R7: Suppose the strobe is first seen low at rising edge n. Then the code sampled at edge n takes effect on `chan_fast`/`quiescent`/`restart` after edge n+2. At that same point `settling` goes high for BLANK_CYCLES cycles (default 1).
- R8: `chan_test` is all zero while `settling` is high. The new test selection appears when `settling` falls.
- R9: Each falling strobe loads exactly once. Holding the strobe low, and changing the code after the 2-cycle hold time, has no effect.
- R10: At most one bit of `chan_test` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_strobe_n | input | 1 | Asynchronous active-low code strobe; high while reset is applied. Minimum low and high times are 1.5 clock periods. |
| ctl_code | input | 4 | Mode code; zero setup time, held for 2 clocks after the strobe falls |
| chan_fast | output | NCH | Per-channel high-speed select |
| chan_test | output | NCH | One-hot test-injection select, blanked while settling |
| quiescent | output | 1 | Chip held idle after a software reset |
| restart | output | 1 | One-cycle pulse on software reset: sequencer back to channel 0 priority |
| settling | output | 1 | High during the post-load blanking window |

## Verification
The assertions check the following on every cycle:
- the test selects are one-hot or empty;
- the test selects are blank while settling;
- a change of speed, or the end of quiescent mode, happens only at a load;
- quiescent mode implies all channels are at low speed;
- the restart pulse lasts one cycle and comes with quiescent.

The decode values for each code, the exact load latency, the single load per strobe, and the persistence rules for test and quiescent across code sequences can be shown only by the bench's code sequences. The same holds for a hardware reset in mid-operation.

// File: rtl/mode_ctl_pkg.sv
package mode_ctl_pkg;

  typedef enum logic [1:0] {
    CLS_SPEED  = 2'd0,
    CLS_UNUSED = 2'd1,
    CLS_SWRST  = 2'd2,
    CLS_TEST   = 2'd3
  } code_cls_e;

  localparam logic [2:0] SPEED_MAX = 3'd4;
  localparam logic [2:0] SWRST_ARG = 3'd7;

  function automatic code_cls_e classify(input logic [3:0] code);
    if (code[3])                   return CLS_TEST;
    else if (code[2:0] <= SPEED_MAX) return CLS_SPEED;
    else if (code[2:0] == SWRST_ARG) return CLS_SWRST;
    else                           return CLS_UNUSED;
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strb_n,
  input  logic [W-1:0] din,
  output logic         fall,
  output logic [W-1:0] dout
);
  logic s1_q, s2_q, s3_q;
  logic [W-1:0] d1_q, d2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
      d1_q <= '0;
      d2_q <= '0;
    end else begin
      s1_q <= strb_n;
      s2_q <= s1_q;
      s3_q <= s2_q;
      d1_q <= din;
      d2_q <= d1_q;
    end
  end

  assign fall = s3_q & ~s2_q;
  assign dout = d2_q;
endmodule

// File: rtl/code_decoder.sv
module code_decoder
  import mode_ctl_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int NFAST = 3
) (
  input  logic [3:0]     code,
  output code_cls_e      cls,
  output logic [NCH-1:0] spd_mask,
  output logic [2:0]     tch
);
  logic [2:0] arg;
  assign arg = code[2:0];
  assign cls = classify(code);
  assign tch = arg;

  for (genvar i = 0; i < NCH; i++) begin : g_mask
    if (i >= NFAST) begin : g_slow
      assign spd_mask[i] = 1'b0;
    end else if (i < 2) begin : g_low_pair
      assign spd_mask[i] = arg[2] | arg[i];
    end else begin : g_group
      assign spd_mask[i] = arg[2];
    end
  end
endmodule

// File: rtl/mode_regs.sv
module mode_regs
  import mode_ctl_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int BLANK_CYCLES = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  code_cls_e      cls,
  input  logic [NCH-1:0] spd_mask,
  input  logic [2:0]     tch,
  output logic [NCH-1:0] fast_q,
  output logic           tact_q,
  output logic [2:0]     tch_q,
  output logic           quiet_q,
  output logic           restart_q,
  output logic           settling
);
  localparam int CW = $clog2(BLANK_CYCLES + 1);
  logic [CW-1:0] blank_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q    <= '0;
      tact_q    <= 1'b0;
      tch_q     <= '0;
      quiet_q   <= 1'b0;
      restart_q <= 1'b0;
      blank_cnt <= '0;
    end else begin
      restart_q <= 1'b0;
      if (blank_cnt != '0) blank_cnt <= blank_cnt - 1'b1;
      if (load) begin
        blank_cnt <= CW'(BLANK_CYCLES);
        unique case (cls)
          CLS_SPEED: begin
            fast_q  <= spd_mask;
            tact_q  <= 1'b0;
            quiet_q <= 1'b0;
          end
          CLS_UNUSED: tact_q <= 1'b0;
          CLS_SWRST: begin
            fast_q    <= '0;
            tact_q    <= 1'b0;
            tch_q     <= '0;
            quiet_q   <= 1'b1;
            restart_q <= 1'b1;
          end
          CLS_TEST: begin
            tact_q <= 1'b1;
            tch_q  <= tch;
          end
          default: ;
        endcase
      end
    end
  end

  assign settling = (blank_cnt != '0);
endmodule

// File: rtl/test_gate.sv
module test_gate #(
  parameter int NCH = 8
) (
  input  logic           tact,
  input  logic [2:0]     tch,
  input  logic           settling,
  output logic [NCH-1:0] sel
);
  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign sel[i] = tact & ~settling & (tch == 3'(i));
  end
endmodule

// File: rtl/mode_ctl_dec.sv
module mode_ctl_dec
  import mode_ctl_pkg::*;
#(
  parameter int NCH          = 8,
  parameter int NFAST        = 3,
  parameter int BLANK_CYCLES = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_strobe_n,
  input  logic [3:0]     ctl_code,
  output logic [NCH-1:0] chan_fast,
  output logic [NCH-1:0] chan_test,
  output logic           quiescent,
  output logic           restart,
  output logic           settling
);
  logic           fall;
  logic [3:0]     code_s;
  code_cls_e      cls;
  logic [NCH-1:0] spd_mask;
  logic [2:0]     tch, tch_q;
  logic           tact_q;

  strobe_sync #(.W(4)) u_sync (
    .clk(clk), .rst_n(rst_n), .strb_n(ctl_strobe_n), .din(ctl_code),
    .fall(fall), .dout(code_s)
  );

  code_decoder #(.NCH(NCH), .NFAST(NFAST)) u_dec (
    .code(code_s), .cls(cls), .spd_mask(spd_mask), .tch(tch)
  );

  mode_regs #(.NCH(NCH), .BLANK_CYCLES(BLANK_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .load(fall), .cls(cls), .spd_mask(spd_mask),
    .tch(tch), .fast_q(chan_fast), .tact_q(tact_q), .tch_q(tch_q),
    .quiet_q(quiescent), .restart_q(restart), .settling(settling)
  );

  test_gate #(.NCH(NCH)) u_gate (
    .tact(tact_q), .tch(tch_q), .settling(settling), .sel(chan_test)
  );
endmodule

// File: rtl/mode_ctl_dec_chk.sv
module mode_ctl_dec_chk #(
  parameter int NCH   = 8,
  parameter int NFAST = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] chan_fast,
  input logic [NCH-1:0] chan_test,
  input logic           quiescent,
  input logic           restart,
  input logic           settling
);
  a_r10_test_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_test));

  a_r8_blank_while_settling: assert property (@(posedge clk) disable iff (!rst_n)
    settling |-> (chan_test == '0));

  a_r7_speed_moves_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_fast) |-> settling);

  a_r5_quiet_exit_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(quiescent) |-> settling);

  a_r4_quiet_all_slow: assert property (@(posedge clk) disable iff (!rst_n)
    quiescent |-> (chan_fast == '0));

  a_r4_restart_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);

  a_r4_restart_with_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> (quiescent && settling));

  a_r2_upper_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_fast >> NFAST) == '0);
endmodule

bind mode_ctl_dec mode_ctl_dec_chk #(.NCH(NCH), .NFAST(NFAST)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_fast(chan_fast), .chan_test(chan_test),
  .quiescent(quiescent), .restart(restart), .settling(settling)
);

// File: tb/mode_ctl_dec_tb_top.sv
module mode_ctl_dec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  typedef struct packed {
    logic [3:0] code;
    logic [7:0] fast;
    logic [7:0] test;
    logic       quiet;
    logic       rst;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'b0001, 8'h01, 8'h00, 1'b0, 1'b0},  // R2
    '{4'b0010, 8'h02, 8'h00, 1'b0, 1'b0},  // R2
    '{4'b0011, 8'h03, 8'h00, 1'b0, 1'b0},  // R2
    '{4'b0100, 8'h07, 8'h00, 1'b0, 1'b0},  // R2
    '{4'b1010, 8'h07, 8'h04, 1'b0, 1'b0},  // R6
    '{4'b1111, 8'h07, 8'h80, 1'b0, 1'b0},  // R6 switch keeps speed
    '{4'b0101, 8'h07, 8'h00, 1'b0, 1'b0},  // R3
    '{4'b1000, 8'h07, 8'h01, 1'b0, 1'b0},  // R6
    '{4'b0110, 8'h07, 8'h00, 1'b0, 1'b0},  // R3
    '{4'b0111, 8'h00, 8'h00, 1'b1, 1'b1},  // R4
    '{4'b1011, 8'h00, 8'h08, 1'b1, 1'b0},  // R5
    '{4'b0101, 8'h00, 8'h00, 1'b1, 1'b0},  // R5
    '{4'b0011, 8'h03, 8'h00, 1'b0, 1'b0},  // R5 exit
    '{4'b0000, 8'h00, 8'h00, 1'b0, 1'b0}   // R2
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           ctl_strobe_n = 1'b1;
  logic [3:0]     ctl_code = '0;
  logic [NCH-1:0] chan_fast, chan_test;
  logic           quiescent, restart, settling;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_ctl_dec dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_strobe_n(ctl_strobe_n), .ctl_code(ctl_code),
    .chan_fast(chan_fast), .chan_test(chan_test), .quiescent(quiescent),
    .restart(restart), .settling(settling)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, "chan_fast", 32'(chan_fast), 32'h0);
    check(req, "chan_test", 32'(chan_test), 32'h0);
    check(req, "quiescent", 32'(quiescent), 32'h0);
    check(req, "restart",   32'(restart),   32'h0);
    check(req, "settling",  32'(settling),  32'h0);
  endtask

  // Drive at a falling edge; N3 is after the load edge, N4 after settling.
  task automatic send(input vec_t v, input string req);
    @(negedge clk);
    ctl_strobe_n = 1'b0;
    ctl_code     = v.code;
    repeat (3) @(negedge clk);
    check({req, " R7"}, "settling at load", 32'(settling), 32'h1);
    check(req, "chan_fast", 32'(chan_fast), 32'(v.fast));
    check(req, "quiescent", 32'(quiescent), 32'(v.quiet));
    check({req, " R4"}, "restart", 32'(restart), 32'(v.rst));
    check({req, " R8"}, "blanked test", 32'(chan_test), 32'h0);
    ctl_strobe_n = 1'b1;
    ctl_code     = ~v.code;
    @(negedge clk);
    check({req, " R7"}, "settling end", 32'(settling), 32'h0);
    check(req, "chan_test", 32'(chan_test), 32'(v.test));
    check({req, " R4"}, "restart gone", 32'(restart), 32'h0);
    @(negedge clk);
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");

    for (int i = 0; i < NV; i++) send(VECS[i], $sformatf("R2/R3/R4/R5/R6 vec%0d", i));

    // R9: strobe held low, code changed after hold time
    send('{4'b0100, 8'h07, 8'h00, 1'b0, 1'b0}, "R9 setup");
    @(negedge clk);
    ctl_strobe_n = 1'b0;
    ctl_code     = 4'b1100;
    repeat (3) @(negedge clk);
    ctl_code = 4'b0111;
    repeat (8) @(negedge clk);
    check("R9", "single load chan_test", 32'(chan_test), 32'h10);
    check("R9", "chan_fast kept", 32'(chan_fast), 32'h07);
    check("R9", "no reload settling", 32'(settling), 32'h0);
    check("R9", "no reload quiescent", 32'(quiescent), 32'h0);
    ctl_strobe_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", "release no load", 32'(chan_test), 32'h10);

    // R1: hardware reset in mid-operation
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("R1 mid reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 mid release");

    // R2: speed code after a test code ends test mode
    v = '{4'b1001, 8'h00, 8'h02, 1'b0, 1'b0};
    send(v, "R6 from reset");
    send('{4'b0010, 8'h02, 8'h00, 1'b0, 1'b0}, "R2 exits test");

    report();
  end
endmodule